// File: doc/BRIEF.md
# Digital Potentiometer Two-Wire Slave Interface

This block is the serial control front end of a 256-position digital potentiometer. It receives the two-wire bus clock and data lines after they have been synchronised to the system clock. It pulls the data line low only through an open-drain enable output, and it never drives the line high. A transaction opens with an identification byte. That byte holds a fixed 5-bit device tag, the two address-strap bits and a direction bit. The byte that follows sets an internal register pointer. After that the master either writes one data byte or issues a repeated START and reads bytes from the pointer onward.

The block holds two registers. Address 0x00 is the live wiper position, which drives the resistor array and changes as soon as its data byte is accepted. Address 0x01 is the non-volatile setting. A byte written there is held pending and is programmed only when the STOP arrives. Programming starts a busy counter, and while that counter runs the block ignores every identification byte. The master therefore writes non-volatile bytes one transaction at a time and polls for an acknowledge to learn when programming has finished.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset the data line is released, the wiper output equals WIPER_INIT (default 0x80), the busy output is low, and the stored non-volatile value equals NV_INIT (default 0x80).
- R2: The identification byte is sent MSB first. Bits [7:3] must equal ID_TAG (default 5'b01010), bits [2:1] must equal the strap input, and bit 0 selects the direction (0 = write, 1 = read). A matching byte is acknowledged by holding the data line low during the ninth SCL cycle.
- R3: A non-matching identification byte is not acknowledged. The data line then stays released until the next START, and later bytes in that transaction change no register.
- R4: In a write, the identification byte, the address byte and one data byte are each acknowledged. A data byte sent to address 0x00 appears on the wiper output by the end of its acknowledge cycle. A further byte in the same transaction is not acknowledged.
- R5: A data byte sent to address 0x01 is programmed into the non-volatile value only when a STOP is detected. A START that arrives before that STOP discards the byte. Reading address 0x01 returns the programmed value.
- R6: Programming raises the busy output for exactly BUSY_CYCLES clock cycles. While busy is high, no identification byte is acknowledged. Once busy falls, identification bytes are acknowledged again.
- R7: A read is a write-direction identification byte, an address byte, a repeated START, then a read-direction identification byte. Data is sent MSB first, starting at the register the address byte selected, and the pointer advances by one after each byte.
- R8: Bytes keep coming while the master acknowledges in the ninth cycle. After a master NACK the data line stays released until the next START or STOP.
- R9: Reading an address other than 0x00 or 0x01 returns 0x00. Writing such an address changes no register.
- R10: The open-drain enable changes only while SCL is low.
- R11: A START or STOP arriving in the middle of a byte abandons that byte. A START restarts reception at the identification byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronised bus clock |
| sda_in | input | 1 | Synchronised bus data, as seen on the wire |
| strap_sel | input | 2 | Address-strap pins, compared with identification bits [2:1] |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| wiper_pos | output | 8 | Current wiper tap position |
| nv_busy | output | 1 | High while non-volatile programming is in progress |

## Verification
A wrong bit counter or wrong protocol state shows on the wire first. An acknowledge lands a bit early or late, or it is missing, and that is visible within the same byte. A pointer that fails to advance, or that starts at the wrong value, returns a wrong byte on the very next read. A non-volatile byte committed at the wrong moment shows in three ways: busy rises without a STOP, busy lasts the wrong number of cycles, or a later read of address 0x01 returns a value that should have been discarded. That last symptom only appears at the next read of that address, so the bench reads it back straight after each cancelled or completed programming step.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECV,
      ST_ACK,
      ST_SEND,
      ST_MACK,
      ST_WAIT
   } link_state_t;

   typedef enum logic [1:0] {
      PH_ID,
      PH_ADDR,
      PH_DATA
   } rx_phase_t;
endpackage

// File: rtl/dpot_bus_cond.sv
module dpot_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_in;
         sda_q <= sda_in;
      end
   end

   assign scl_rise  = scl_in & ~scl_q;
   assign scl_fall  = ~scl_in & scl_q;
   assign start_evt = scl_in & scl_q & sda_q & ~sda_in;
   assign stop_evt  = scl_in & scl_q & ~sda_q & sda_in;
endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_WIPER  = 0,
   parameter int unsigned ADDR_NV     = 1,
   parameter logic [DATA_W-1:0] WIPER_INIT = 8'h80,
   parameter logic [DATA_W-1:0] NV_INIT    = 8'h80,
   parameter int unsigned BUSY_CYCLES = 1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [DATA_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] wiper,
   output logic              busy
);
   localparam logic [DATA_W-1:0] A_WIP = DATA_W'(ADDR_WIPER);
   localparam logic [DATA_W-1:0] A_NV  = DATA_W'(ADDR_NV);

   logic              nv_pend;
   logic [DATA_W-1:0] nv_pend_d, nv_val, wiper_q;
   logic              commit;

   assign commit = stop_evt & nv_pend & ~start_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wiper_q   <= WIPER_INIT;
         nv_val    <= NV_INIT;
         nv_pend   <= 1'b0;
         nv_pend_d <= '0;
      end else begin
         if (wr_en && wr_addr == A_WIP) wiper_q <= wr_data;
         if (start_evt) begin
            nv_pend <= 1'b0;
         end else if (commit) begin
            nv_val  <= nv_pend_d;
            nv_pend <= 1'b0;
         end else if (wr_en && wr_addr == A_NV) begin
            nv_pend   <= 1'b1;
            nv_pend_d <= wr_data;
         end
      end
   end

   assign wiper   = wiper_q;
   assign rd_data = (rd_addr == A_WIP) ? wiper_q :
                    (rd_addr == A_NV)  ? nv_val  : '0;

   generate
      if (BUSY_CYCLES > 0) begin : g_busy
         localparam int BW = $clog2(BUSY_CYCLES + 1);
         logic [BW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (commit)     cnt <= BW'(BUSY_CYCLES);
            else if (cnt != '0)  cnt <= cnt - BW'(1);
         end
         assign busy = (cnt != '0);

         assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy) |-> $past(stop_evt));
         assert_busy_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt != '0) |=> (cnt == $past(cnt) - BW'(1)));
      end else begin : g_nobusy
         assign busy = 1'b0;
      end
   endgenerate

   assert_wiper_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_q) |-> ($past(wr_en) && $past(wr_addr) == A_WIP));
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave #(
   parameter int unsigned DATA_W      = 8,
   parameter logic [DATA_W-4:0] ID_TAG = 5'b01010,
   parameter int unsigned ADDR_WIPER  = 0,
   parameter int unsigned ADDR_NV     = 1,
   parameter logic [DATA_W-1:0] WIPER_INIT = 8'h80,
   parameter logic [DATA_W-1:0] NV_INIT    = 8'h80,
   parameter int unsigned BUSY_CYCLES = 1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [1:0]        strap_sel,
   output logic              sda_oe,
   output logic [DATA_W-1:0] wiper_pos,
   output logic              nv_busy
);
   import dpot_pkg::*;

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST_TX   = CNT_W'(DATA_W - 1);

   initial begin
      assert (DATA_W >= 4) else $error("DATA_W too small for tag, strap and direction");
      assert (ADDR_WIPER != ADDR_NV) else $error("register addresses collide");
   end

   logic scl_rise, scl_fall, start_evt, stop_evt;
   link_state_t       state, ack_next;
   rx_phase_t         phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg, txsh, ptr, rd_data;
   logic              wr_en, id_match;

   dpot_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   assign wr_en = (state == ST_RECV) && (phase == PH_DATA) && scl_fall &&
                  (bit_cnt == FULL_BYTE) && !start_evt && !stop_evt;

   dpot_regfile #(
      .DATA_W(DATA_W), .ADDR_WIPER(ADDR_WIPER), .ADDR_NV(ADDR_NV),
      .WIPER_INIT(WIPER_INIT), .NV_INIT(NV_INIT), .BUSY_CYCLES(BUSY_CYCLES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
      .start_evt(start_evt), .stop_evt(stop_evt), .rd_addr(ptr),
      .rd_data(rd_data), .wiper(wiper_pos), .busy(nv_busy)
   );

   assign id_match = (shreg[DATA_W-1:3] == ID_TAG) && (shreg[2:1] == strap_sel) && !nv_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ack_next <= ST_IDLE;
         phase    <= PH_ID;
         bit_cnt  <= '0;
         shreg    <= '0;
         txsh     <= '0;
         ptr      <= '0;
         sda_oe   <= 1'b0;
      end else if (start_evt) begin
         state   <= ST_RECV;
         phase   <= PH_ID;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
      end else if (stop_evt) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_RECV: begin
               if (scl_rise && bit_cnt != FULL_BYTE) begin
                  shreg   <= {shreg[DATA_W-2:0], sda_in};
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end else if (scl_fall && bit_cnt == FULL_BYTE) begin
                  bit_cnt <= '0;
                  case (phase)
                     PH_ID: begin
                        if (id_match) begin
                           sda_oe <= 1'b1;
                           state  <= ST_ACK;
                           if (shreg[0]) begin
                              ack_next <= ST_SEND;
                           end else begin
                              ack_next <= ST_RECV;
                              phase    <= PH_ADDR;
                           end
                        end else begin
                           state <= ST_WAIT;
                        end
                     end
                     PH_ADDR: begin
                        ptr      <= shreg;
                        sda_oe   <= 1'b1;
                        state    <= ST_ACK;
                        ack_next <= ST_RECV;
                        phase    <= PH_DATA;
                     end
                     default: begin
                        sda_oe   <= 1'b1;
                        state    <= ST_ACK;
                        ack_next <= ST_WAIT;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  state   <= ack_next;
                  bit_cnt <= '0;
                  if (ack_next == ST_SEND) begin
                     txsh   <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                  end else begin
                     sda_oe <= 1'b0;
                  end
               end
            end
            ST_SEND: begin
               if (scl_fall) begin
                  if (bit_cnt == LAST_TX) begin
                     sda_oe  <= 1'b0;
                     state   <= ST_MACK;
                     ptr     <= ptr + DATA_W'(1);
                     bit_cnt <= '0;
                  end else begin
                     txsh    <= {txsh[DATA_W-2:0], 1'b0};
                     sda_oe  <= ~txsh[DATA_W-2];
                     bit_cnt <= bit_cnt + CNT_W'(1);
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  if (!sda_in) begin
                     state    <= ST_ACK;
                     ack_next <= ST_SEND;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_in);
   assert_quiet_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !sda_oe);
   assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nv_busy |-> (state != ST_ACK && state != ST_SEND));
   assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_SEND && state == ST_MACK) |-> (ptr == $past(ptr) + DATA_W'(1)));
endmodule

// File: tb/dpot_i2c_slave_test.sv
module dpot_i2c_slave_test;
   localparam int Q      = 4;
   localparam int BUSY_T = 300;
   localparam logic [7:0] IDW  = 8'h54;   // tag 01010, strap 10, write
   localparam logic [7:0] IDR  = 8'h55;   // same, read
   localparam logic [7:0] IDBD = 8'h52;   // strap 01: mismatch

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
   logic [1:0] strap = 2'b10;
   logic sda_oe, busy;
   logic [7:0] wiper;
   logic sda_bus;
   assign sda_bus = sda_m & ~sda_oe;

   always #10 clk = ~clk;

   dpot_i2c_slave #(.BUSY_CYCLES(BUSY_T)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
      .strap_sel(strap), .sda_oe(sda_oe), .wiper_pos(wiper), .nv_busy(busy)
   );

   int n_run = 0, n_fail = 0;
   int exp_q[$], obs_q[$];
   string tag_q[$];
   bit done = 1'b0;
   int busy_len = 0, r10_bad = 0;
   logic oe_prev = 1'b0;

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      while (obs_q.size() > 0 && exp_q.size() > 0)
         check(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
   end

   always @(negedge clk) if (busy) busy_len++;

   always @(posedge clk) begin
      #1;
      if (rst_n && sda_oe != oe_prev && scl) r10_bad++;
      oe_prev = sda_oe;
   end

   task automatic qtr(); repeat (Q) @(negedge clk); endtask
   task automatic bus_start();
      sda_m = 1'b1; qtr(); scl = 1'b1; qtr(); sda_m = 1'b0; qtr(); scl = 1'b0; qtr();
   endtask
   task automatic bus_stop();
      sda_m = 1'b0; qtr(); scl = 1'b1; qtr(); sda_m = 1'b1; qtr();
   endtask
   task automatic put_bit(input logic b);
      sda_m = b; qtr(); scl = 1'b1; qtr(); qtr(); scl = 1'b0; qtr();
   endtask
   task automatic get_bit(output logic b);
      sda_m = 1'b1; qtr(); scl = 1'b1; qtr(); b = sda_bus; qtr(); scl = 1'b0; qtr();
   endtask
   task automatic send_byte(input logic [7:0] v, input int exp_ack, input string tag);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      exp_q.push_back(exp_ack); tag_q.push_back(tag);
      get_bit(a);
      obs_q.push_back(int'(a));
   endtask
   task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
      logic [7:0] v;
      logic b;
      for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
      exp_q.push_back(int'(exp)); tag_q.push_back(tag);
      obs_q.push_back(int'(v));
      put_bit(mack);
   endtask
   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic b;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 sda released", sda_oe, 0);
      check("R1 wiper init", wiper, 8'h80);
      check("R1 busy low", busy, 0);

      // R2/R4 write wiper
      bus_start();
      send_byte(IDW, 0, "R2 id ack");
      send_byte(8'h00, 0, "R4 addr ack");
      send_byte(8'h3C, 0, "R4 data ack");
      check("R4 wiper updated", wiper, 8'h3C);
      send_byte(8'hFF, 1, "R4 extra byte nack");
      bus_stop();
      check("R4 wiper after stop", wiper, 8'h3C);

      // R3 mismatch
      bus_start();
      send_byte(IDBD, 1, "R3 id nack");
      send_byte(8'h00, 1, "R3 addr ignored");
      send_byte(8'h11, 1, "R3 data ignored");
      bus_stop();
      check("R3 wiper unchanged", wiper, 8'h3C);

      // R5 cancel by repeated START
      bus_start();
      send_byte(IDW, 0, "R5 id ack");
      send_byte(8'h01, 0, "R5 addr ack");
      send_byte(8'hA5, 0, "R5 data ack");
      bus_start();
      bus_stop();
      repeat (3) @(negedge clk);
      check("R5 no programming after cancel", busy, 0);

      // R7/R8/R9 read sequence
      bus_start();
      send_byte(IDW, 0, "R7 id w ack");
      send_byte(8'h00, 0, "R7 addr ack");
      bus_start();
      send_byte(IDR, 0, "R7 id r ack");
      recv_byte(8'h3C, 1'b0, "R7 byte0 wiper");
      recv_byte(8'h80, 1'b0, "R5 byte1 nv kept after cancel");
      recv_byte(8'h00, 1'b1, "R9 unimplemented reads zero");
      get_bit(b);
      check("R8 released after nack", b, 1);
      bus_stop();

      // R5/R6 NV programming
      busy_len = 0;
      bus_start();
      send_byte(IDW, 0, "R6 id ack");
      send_byte(8'h01, 0, "R6 addr ack");
      send_byte(8'h5A, 0, "R6 data ack");
      check("R5 not busy before stop", busy, 0);
      bus_stop();
      check("R6 busy after stop", busy, 1);
      check("R5 wiper untouched", wiper, 8'h3C);
      bus_start();
      send_byte(IDW, 1, "R6 id nack while busy");
      bus_stop();
      for (int i = 0; i < 2 * BUSY_T && busy; i++) @(negedge clk);
      @(negedge clk);
      check("R6 busy length", busy_len, BUSY_T);
      bus_start();
      send_byte(IDW, 0, "R6 id ack after busy");
      send_byte(8'h01, 0, "R5 addr ack");
      bus_start();
      send_byte(IDR, 0, "R5 id r ack");
      recv_byte(8'h5A, 1'b1, "R5 nv programmed");
      bus_stop();

      // R9 write to unimplemented address
      bus_start();
      send_byte(IDW, 0, "R9 id ack");
      send_byte(8'h07, 0, "R9 addr ack");
      send_byte(8'h99, 0, "R9 data ack");
      bus_stop();
      check("R9 busy unaffected", busy, 0);
      bus_start();
      send_byte(IDW, 0, "R9 id ack 2");
      send_byte(8'h07, 0, "R9 addr ack 2");
      bus_start();
      send_byte(IDR, 0, "R9 id r ack");
      recv_byte(8'h00, 1'b0, "R9 read zero");
      recv_byte(8'h00, 1'b1, "R7 pointer moved to 08");
      bus_stop();
      check("R9 wiper unchanged", wiper, 8'h3C);

      // R11 START mid-byte restarts
      bus_start();
      send_byte(IDW, 0, "R11 id ack");
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      bus_start();
      send_byte(IDW, 0, "R11 id ack after restart");
      send_byte(8'h00, 0, "R11 addr ack");
      send_byte(8'h77, 0, "R11 data ack");
      bus_stop();
      check("R11 wiper after restart", wiper, 8'h77);

      repeat (20) @(negedge clk);
      check("R10 enable changed only with scl low", r10_bad, 0);
      check("scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule